// File: doc/BRIEF.md
# Power-Fail Reset and Chip-Enable Gating Supervisor

This block is the digital core of a supply supervisor that turns a battery-backed static RAM into non-volatile storage. An external comparator supplies a raw power-valid flag, a host or push-button supplies an active-low manual reset request, and the host drives an active-low chip enable meant for the RAM. The block resynchronises both asynchronous inputs. It drives an active-low system reset and a conditioned chip enable that keeps the RAM deselected whenever the supply cannot be trusted.

The reset output stays asserted while the supply is invalid. Once the supply recovers, it stays asserted for a further recovery interval so that the rails can settle. A manual reset request counts only when it stays low for a qualifying number of clock cycles. Shorter pulses are treated as noise and discarded. A qualified request runs through the same recovery sequence as a power cycle. If a new reset cause appears while recovery is in progress, the recovery count starts again from zero. When the supply is valid, the host chip enable reaches the RAM through logic alone, with no register in its path.

All durations are parameters in clock cycles. `QUAL_CYC` is the minimum manual pulse width and `REC_CYC` is the recovery interval. Choose `REC_CYC` so that the interval lies between 40 ms and 200 ms at the system clock rate. Choose `QUAL_CYC` so that pulses of 200 ns or more qualify and pulses under 50 ns never qualify.

Top module: `pwr_supervisor`

## Requirements
- R1: Within three clock edges of `pwrOkRaw` going low, `rstOutN` is 0, and it stays 0 for as long as `pwrOkRaw` stays low.
- R2: Let k be the first rising clock edge that samples `pwrOkRaw` high, with `mrReqN` high and no reset cause afterwards. `rstOutN` goes from 0 to 1 on edge k+REC_CYC+2.
- R3: A manual request is `mrReqN` sampled low on at least QUAL_CYC consecutive rising edges. It drives `rstOutN` to 0. Let k be the first edge that samples `mrReqN` high again. `rstOutN` returns to 1 on edge k+REC_CYC+3.
- R4: A low pulse on `mrReqN` spanning fewer than QUAL_CYC sampling edges never drives `rstOutN` low.
- R5: If `pwrOkRaw` drops during the recovery interval, even for one cycle, recovery restarts. `rstOutN` rises REC_CYC+2 edges after the first edge that samples it high again, and it does not rise before then.
- R6: A qualified manual request during the recovery interval restarts recovery. `rstOutN` rises REC_CYC+3 edges after that request is released, and it does not rise before then.
- R7: While the synchronised supply flag is invalid, `sramCeN` is 1 whatever the value of `hostCeN`. This holds in particular from the third edge after `pwrOkRaw` falls.
- R8: While the synchronised supply flag is valid, `sramCeN` equals `hostCeN` in the same time step, with no clock cycle of latency.
- R9: While `rstN` is low, and afterwards until a recovery interval completes, `rstOutN` is 0. While the supply is invalid after reset, `sramCeN` is 1.
- R10: While a qualified manual request is still held low, `rstOutN` stays 0, however long the hold lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset of the block's registers |
| pwrOkRaw | input | 1 | Asynchronous supply-valid flag from the comparator, 1 = supply valid |
| mrReqN | input | 1 | Asynchronous active-low manual reset request |
| hostCeN | input | 1 | Active-low chip enable from the host |
| rstOutN | output | 1 | Active-low system reset, registered |
| sramCeN | output | 1 | Active-low conditioned chip enable to the RAM |

## Verification
The assertions assume that `rstN` is applied at start-up, and that `pwrOkRaw` and `mrReqN` are levels which the synchronisers may see at any phase; `hostCeN` may take any value. The R7 property also assumes that the synchroniser depth is two stages. The stimulus changes every input on the falling clock edge and holds each level for whole cycles, so the number of edges that see a pulse is exact. The bench computes each expected reset-release cycle from the edge at which the last cause ended. It changes `hostCeN` only while the supply state is steady.

// File: rtl/pwrsup_pkg.sv
package pwrsup_pkg;

  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_RECOVER = 2'd1,
    ST_RUN     = 2'd2
  } supState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic qualClr;
    logic qualInc;
    logic recClr;
    logic recInc;
  } supStrobe_t;

  // Status returned by the datapath
  typedef struct packed {
    logic qualDone;
    logic recDone;
  } supStatus_t;

endpackage

// File: rtl/pwrsup_sync.sv
module pwrsup_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[g] <= RST_VAL;
          else       stage[g] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[g] <= RST_VAL;
          else       stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/pwrsup_ctrl.sv
module pwrsup_ctrl
  import pwrsup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrOk,
  input  logic       mrLow,
  input  supStatus_t stat,
  output supStrobe_t strb,
  output logic       rstOutN
);

  supState_t state, stateNxt;
  logic      resetCause;

  assign resetCause = !pwrOk || stat.qualDone;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_HOLD:    if (!resetCause) stateNxt = ST_RECOVER;
      ST_RECOVER: begin
        if (resetCause)        stateNxt = ST_HOLD;
        else if (stat.recDone) stateNxt = ST_RUN;
      end
      ST_RUN:     if (resetCause) stateNxt = ST_HOLD;
      default:    stateNxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNxt;
  end

  always_comb begin
    strb.qualClr = !mrLow;
    strb.qualInc = mrLow && !stat.qualDone;
    strb.recClr  = (state != ST_RECOVER) || resetCause;
    strb.recInc  = (state == ST_RECOVER) && !resetCause;
  end

  assign rstOutN = (state == ST_RUN);

  // R1: an invalid supply forces reset on the next cycle
  p_pwr_bad_holds_r1: assert property (@(posedge clk) disable iff (!rstN)
    !pwrOk |=> !rstOutN);

  // R2: reset is released only when the recovery counter has expired
  p_release_on_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstOutN) |-> $past(stat.recDone));

  // R4: without a qualified request and with a valid supply, reset is not asserted
  p_no_glitch_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rstOutN && pwrOk && !stat.qualDone) |=> rstOutN);

  // R10: a qualified request that is still held keeps reset asserted
  p_held_request_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mrLow && stat.qualDone) |=> !rstOutN);

endmodule

// File: rtl/pwrsup_dpath.sv
module pwrsup_dpath
  import pwrsup_pkg::*;
#(
  parameter int QUAL_CYC = 10,
  parameter int REC_CYC  = 5_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  supStrobe_t strb,
  input  logic       pwrOk,
  input  logic       hostCeN,
  output supStatus_t stat,
  output logic       sramCeN
);

  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam int RW = $clog2(REC_CYC + 1);

  logic [QW-1:0] qualCnt;
  logic [RW-1:0] recCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             qualCnt <= '0;
    else if (strb.qualClr) qualCnt <= '0;
    else if (strb.qualInc) qualCnt <= qualCnt + QW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            recCnt <= '0;
    else if (strb.recClr) recCnt <= '0;
    else if (strb.recInc) recCnt <= recCnt + RW'(1);
  end

  assign stat.qualDone = (qualCnt == QW'(QUAL_CYC));
  assign stat.recDone  = (recCnt == RW'(REC_CYC - 1));

  // Write-protect gate: combinational pass-through when the supply is valid
  assign sramCeN = hostCeN | ~pwrOk;

  // R5: every counting run of the recovery counter starts from zero
  p_count_from_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.recInc && !$past(strb.recInc)) |-> (recCnt == '0));

  // R8: with the supply valid, the host enable reaches the RAM unchanged
  always_comb begin
    if (rstN && pwrOk)
      p_ce_follow_r8: assert (sramCeN == hostCeN);
  end

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
  import pwrsup_pkg::*;
#(
  parameter int QUAL_CYC    = 10,
  parameter int REC_CYC     = 5_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrOkRaw,
  input  logic mrReqN,
  input  logic hostCeN,
  output logic rstOutN,
  output logic sramCeN
);

  logic [1:0] syncVec;
  logic       pwrOk;
  logic       mrLow;
  supStrobe_t strb;
  supStatus_t stat;

  // Bit 1: manual request (idle 1), bit 0: supply valid (reset 0)
  pwrsup_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b10)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({mrReqN, pwrOkRaw}),
    .syncOut(syncVec)
  );

  assign pwrOk = syncVec[0];
  assign mrLow = !syncVec[1];

  pwrsup_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .pwrOk  (pwrOk),
    .mrLow  (mrLow),
    .stat   (stat),
    .strb   (strb),
    .rstOutN(rstOutN)
  );

  pwrsup_dpath #(
    .QUAL_CYC(QUAL_CYC),
    .REC_CYC (REC_CYC)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .pwrOk  (pwrOk),
    .hostCeN(hostCeN),
    .stat   (stat),
    .sramCeN(sramCeN)
  );

  // R7: a supply flag that has been low for three edges deselects the RAM
  p_ce_blocked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrOkRaw && !$past(pwrOkRaw) && !$past(pwrOkRaw, 2)) |-> sramCeN);

endmodule

// File: tb/pwr_supervisor_tb.sv
module pwr_supervisor_tb;

  localparam int QUAL = 4;
  localparam int REC  = 20;

  logic clk = 1'b0;
  logic rstN;
  logic pwrOkRaw;
  logic mrReqN;
  logic hostCeN;
  logic rstOutN;
  logic sramCeN;

  int cyc = 0;
  int nTests = 0;
  int nFail = 0;
  int fallCount = 0;
  logic prevRst = 1'b0;
  bit done = 1'b0;

  int    expCyc[$];
  string expTag[$];

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  pwr_supervisor #(
    .QUAL_CYC(QUAL),
    .REC_CYC (REC)
  ) u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .pwrOkRaw(pwrOkRaw),
    .mrReqN  (mrReqN),
    .hostCeN (hostCeN),
    .rstOutN (rstOutN),
    .sramCeN (sramCeN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side: the release is made at this negedge; the first edge to see it is cyc+1
  task automatic expectRise(input int extra, input string tag);
    expCyc.push_back(cyc + 1 + REC + extra);
    expTag.push_back(tag);
  endtask

  // Monitor: samples between edges and matches each reset release against the queue
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (rstOutN && !prevRst) begin
        if (expCyc.size() == 0) begin
          check(1'b0, "unexpected reset release", cyc, -1);
        end else begin
          int    e;
          string t;
          e = expCyc.pop_front();
          t = expTag.pop_front();
          check(cyc == e, {t, " release cycle"}, cyc, e);
        end
      end
      if (!rstOutN && prevRst) fallCount++;
    end
    prevRst = rstOutN;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int f0;
    rstN = 1'b0; pwrOkRaw = 1'b0; mrReqN = 1'b1; hostCeN = 1'b0;
    step(3);
    rstN = 1'b1;
    step(2);
    check(rstOutN == 1'b0, "R9 reset out after reset", rstOutN, 0);
    check(sramCeN == 1'b1, "R9 ce after reset", sramCeN, 1);

    // R7: host enable toggles while supply invalid
    hostCeN = 1'b1; #1;
    check(sramCeN == 1'b1, "R7 ce blocked host=1", sramCeN, 1);
    step(1); hostCeN = 1'b0; #1;
    check(sramCeN == 1'b1, "R7 ce blocked host=0", sramCeN, 1);

    // R2: power-up recovery
    step(1);
    pwrOkRaw = 1'b1;
    expectRise(2, "R2");
    step(REC + 10);
    check(rstOutN == 1'b1, "R2 released", rstOutN, 1);

    // R8: combinational pass-through
    hostCeN = 1'b1; #1;
    check(sramCeN == 1'b1, "R8 follow 1", sramCeN, 1);
    #2; hostCeN = 1'b0; #1;
    check(sramCeN == 1'b0, "R8 follow 0", sramCeN, 0);
    step(1); hostCeN = 1'b1; #1;
    check(sramCeN == 1'b1, "R8 follow 1 again", sramCeN, 1);
    step(1); hostCeN = 1'b0; #1;
    check(sramCeN == 1'b0, "R8 follow 0 again", sramCeN, 0);

    // R4: pulse one edge short of qualifying
    step(1);
    f0 = fallCount;
    mrReqN = 1'b0;
    step(QUAL - 1);
    mrReqN = 1'b1;
    step(10);
    check(fallCount == f0, "R4 short pulse no reset", fallCount - f0, 0);
    check(rstOutN == 1'b1, "R4 reset still high", rstOutN, 1);

    // R4: single-edge pulse
    mrReqN = 1'b0;
    step(1);
    mrReqN = 1'b1;
    step(10);
    check(fallCount == f0, "R4 one-edge pulse no reset", fallCount - f0, 0);

    // R3: pulse of exactly QUAL edges
    f0 = fallCount;
    mrReqN = 1'b0;
    step(QUAL);
    mrReqN = 1'b1;
    expectRise(3, "R3");
    step(4);
    check(fallCount == f0 + 1, "R3 qualified pulse resets", fallCount - f0, 1);
    step(REC + 10);

    // R10: long hold keeps reset asserted
    mrReqN = 1'b0;
    step(REC * 2);
    check(rstOutN == 1'b0, "R10 held request", rstOutN, 0);
    mrReqN = 1'b1;
    expectRise(3, "R10");
    step(REC + 10);

    // R1 / R7: power loss
    pwrOkRaw = 1'b0;
    step(3);
    check(rstOutN == 1'b0, "R1 reset on power loss", rstOutN, 0);
    hostCeN = 1'b0; #1;
    check(sramCeN == 1'b1, "R7 ce blocked on loss", sramCeN, 1);
    step(5);
    check(rstOutN == 1'b0, "R1 reset stays low", rstOutN, 0);

    // R5: one-cycle dropout during recovery
    pwrOkRaw = 1'b1;
    step(REC / 2);
    pwrOkRaw = 1'b0;
    step(1);
    pwrOkRaw = 1'b1;
    expectRise(2, "R5");
    step(REC + 10);

    // R6: qualified request during recovery
    mrReqN = 1'b0;
    step(QUAL);
    mrReqN = 1'b1;
    step(REC / 2);
    mrReqN = 1'b0;
    step(QUAL);
    mrReqN = 1'b1;
    expectRise(3, "R6");
    step(REC + 10);

    check(expCyc.size() == 0, "R2 all expected releases seen", expCyc.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule